// File: doc/BRIEF.md
# Register-Mapped Arithmetic Unit

This block is a memory-mapped slave that performs one 32-bit integer operation on two operands held in its own registers. Software writes the two operands and an operation code through a simple request/response register bus. It then reads the result location, and that read triggers the computation. The outcome is latched into a stored result register and returned in the same response. A read-only identification word lets software confirm that the block is present. An error flag records whether the most recent computation met an operation code it does not know.

Each request is a single cycle. The bus carries a valid strobe, a write enable, a byte address, an access size in bytes, and 64 bits of write data. Exactly one cycle later the block answers with a one-cycle response strobe and, for reads, the registered read data. A small response state machine tracks this. It has three states. RSP_IDLE means no response is due. RSP_READ means read data is being presented. RSP_WACK means a write is being acknowledged. Every state can move to every other state, and each move is decided by the request in the current cycle: a read request goes to RSP_READ, a write request goes to RSP_WACK, and no request goes to RSP_IDLE.

Access size is checked before any decoding. Below offset 0x80 only 4-byte accesses are legal. At or above 0x80, both 4-byte and 8-byte accesses are legal. An illegal access reads as all ones and changes no state.

Top module: `calc_regblock`

## Requirements
- R1: After reset, operand A (offset 0x10) reads 0x00000002, operand B (offset 0x14) reads 0x00000004, the opcode (offset 0x18) reads 0x000000AA, and `calc_err` is 0. The stored result resets to 0x000000BB.
- R2: A legal 4-byte read of offset 0x00 returns 0x0000000001234567 (the upper 32 bits are zero), whatever was written before.
- R3: Legal 4-byte writes to 0x10, 0x14 and 0x18 store the low 32 bits of `req_wdata`. Reads of those offsets return the stored value, zero-extended to 64 bits.
- R4: A legal read of offset 0x30 with opcode 1 returns operand A + operand B, modulo 2^32.
- R5: A legal read of offset 0x30 with opcode 2 returns operand A − operand B, modulo 2^32.
- R6: A legal read of offset 0x30 with opcode 3 returns the low 32 bits of operand A × operand B.
- R7: A legal read of offset 0x30 with any other opcode returns 0xFF and sets `calc_err` to 1. A legal result read with opcode 1, 2 or 3 clears `calc_err` to 0.
- R8: `req_size` is the access width in bytes. Below offset 0x80, any size other than 4 reads as all ones and a write of that size changes nothing. A wrong-size read of 0x30 neither computes nor changes `calc_err`.
- R9: Reads of unmapped offsets return all ones. This includes offsets at or above 0x80 with size 4 or 8, and also other sizes there. Writes to any offset other than 0x10, 0x14 and 0x18 are ignored.
- R10: `rsp_valid` is high in exactly the cycle after each request and low otherwise. Read data appears in that response cycle, and a result read carries the newly computed value.
- R11: Reads and writes of the operand, opcode and identification registers never change `calc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte offset |
| req_size | input | 4 | Access width in bytes (1, 2, 4, 8) |
| req_wdata | input | DATA_W (64) | Write data; the low 32 bits are used |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | DATA_W (64) | Read data; zero during a write acknowledge |
| calc_err | output | 1 | Invalid-opcode indicator from the last result read |

## Verification
A result read does two things in one clock edge. It latches the new result and error flag, and it registers the response data, so these two functions land in the same cycle. The bench provokes this by issuing a result read in the cycle right after an operand or opcode write, with no idle gap. It then judges the response word and `calc_err` together in the response cycle. A stale operand, a stale stored result, or a flag that lags by one read each shows up as a mismatch in that single sample.

// File: rtl/calc_pkg.sv
package calc_pkg;

    localparam logic [31:0] ID_WORD    = 32'h0123_4567;
    localparam int unsigned OFS_ID     = 'h00;
    localparam int unsigned OFS_OPA    = 'h10;
    localparam int unsigned OFS_OPB    = 'h14;
    localparam int unsigned OFS_OPC    = 'h18;
    localparam int unsigned OFS_RES    = 'h30;
    localparam int unsigned WIDE_BASE  = 'h80;

    localparam logic [31:0] RST_OPA    = 32'h0000_0002;
    localparam logic [31:0] RST_OPB    = 32'h0000_0004;
    localparam logic [31:0] RST_OPC    = 32'h0000_00AA;
    localparam logic [31:0] RST_RES    = 32'h0000_00BB;
    localparam logic [31:0] BAD_RESULT = 32'h0000_00FF;

    localparam logic [31:0] OPC_ADD    = 32'd1;
    localparam logic [31:0] OPC_SUB    = 32'd2;
    localparam logic [31:0] OPC_MUL    = 32'd3;

    localparam int unsigned NUM_RW     = 3;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_READ = 2'd1,
        RSP_WACK = 2'd2
    } rsp_state_e;

    typedef enum logic [2:0] {
        SEL_ID   = 3'd0,
        SEL_OPA  = 3'd1,
        SEL_OPB  = 3'd2,
        SEL_OPC  = 3'd3,
        SEL_RES  = 3'd4,
        SEL_NONE = 3'd5
    } reg_sel_e;

    function automatic logic [31:0] rw_reset_value(input int unsigned idx);
        case (idx)
            0:       return RST_OPA;
            1:       return RST_OPB;
            default: return RST_OPC;
        endcase
    endfunction

endpackage

// File: rtl/calc_access_filter.sv
module calc_access_filter
    import calc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output logic              size_ok,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] WIDE_A = ADDR_W'(WIDE_BASE);

    logic wide_region;

    always_comb begin
        wide_region = (addr >= WIDE_A);
        if (wide_region) begin
            size_ok = (size == 4'd4) || (size == 4'd8);
        end else begin
            size_ok = (size == 4'd4);
        end
    end

    always_comb begin
        if (addr == ADDR_W'(OFS_ID)) begin
            sel = SEL_ID;
        end else if (addr == ADDR_W'(OFS_OPA)) begin
            sel = SEL_OPA;
        end else if (addr == ADDR_W'(OFS_OPB)) begin
            sel = SEL_OPB;
        end else if (addr == ADDR_W'(OFS_OPC)) begin
            sel = SEL_OPC;
        end else if (addr == ADDR_W'(OFS_RES)) begin
            sel = SEL_RES;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic [REG_W-1:0] op_a,
    input  logic [REG_W-1:0] op_b,
    input  logic [REG_W-1:0] opcode,
    output logic [REG_W-1:0] result,
    output logic             invalid
);

    localparam int unsigned PROD_W = 2 * REG_W;

    logic [PROD_W-1:0] product;

    always_comb begin
        product = PROD_W'(op_a) * PROD_W'(op_b);
    end

    always_comb begin
        invalid = 1'b0;
        if (opcode == REG_W'(OPC_ADD)) begin
            result = op_a + op_b;
        end else if (opcode == REG_W'(OPC_SUB)) begin
            result = op_a - op_b;
        end else if (opcode == REG_W'(OPC_MUL)) begin
            result = product[REG_W-1:0];
        end else begin
            result  = REG_W'(BAD_RESULT);
            invalid = 1'b1;
        end
    end

endmodule

// File: rtl/calc_regfile.sv
module calc_regfile
    import calc_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_RW-1:0]       wr_en,
    input  logic [REG_W-1:0]        wr_data,
    input  logic                    res_upd,
    input  logic [REG_W-1:0]        res_in,
    input  logic                    err_in,
    output logic [REG_W-1:0]        rw_q [NUM_RW],
    output logic [REG_W-1:0]        res_q,
    output logic                    err_q
);

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rw_q[g] <= REG_W'(rw_reset_value(g));
            end else if (wr_en[g]) begin
                rw_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= REG_W'(RST_RES);
            err_q <= 1'b0;
        end else if (res_upd) begin
            res_q <= res_in;
            err_q <= err_in;
        end
    end

endmodule

// File: rtl/calc_regblock.sv
module calc_regblock
    import calc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              calc_err
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    rsp_state_e        state_q;
    rsp_state_e        state_nxt;
    logic              size_ok;
    reg_sel_e          sel;
    logic [NUM_RW-1:0] wr_en;
    logic [REG_W-1:0]  rw_q [NUM_RW];
    logic [REG_W-1:0]  res_q;
    logic [REG_W-1:0]  alu_res;
    logic              alu_bad;
    logic              res_upd;
    logic [DATA_W-1:0] rd_mux;
    logic              legal;

    calc_access_filter #(.ADDR_W(ADDR_W)) u_filter (
        .addr    (req_addr),
        .size    (req_size),
        .size_ok (size_ok),
        .sel     (sel)
    );

    calc_alu #(.REG_W(REG_W)) u_alu (
        .op_a    (rw_q[0]),
        .op_b    (rw_q[1]),
        .opcode  (rw_q[2]),
        .result  (alu_res),
        .invalid (alu_bad)
    );

    always_comb begin
        legal   = req_valid && size_ok;
        res_upd = legal && !req_write && (sel == SEL_RES);
        wr_en   = '0;
        if (legal && req_write) begin
            wr_en[0] = (sel == SEL_OPA);
            wr_en[1] = (sel == SEL_OPB);
            wr_en[2] = (sel == SEL_OPC);
        end
    end

    calc_regfile #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (req_wdata[REG_W-1:0]),
        .res_upd (res_upd),
        .res_in  (alu_res),
        .err_in  (alu_bad),
        .rw_q    (rw_q),
        .res_q   (res_q),
        .err_q   (calc_err)
    );

    // Read data selection; the result path takes the fresh ALU output.
    always_comb begin
        rd_mux = ALL_ONES;
        if (size_ok) begin
            unique case (sel)
                SEL_ID:   rd_mux = DATA_W'(ID_WORD);
                SEL_OPA:  rd_mux = DATA_W'(rw_q[0]);
                SEL_OPB:  rd_mux = DATA_W'(rw_q[1]);
                SEL_OPC:  rd_mux = DATA_W'(rw_q[2]);
                SEL_RES:  rd_mux = DATA_W'(alu_res);
                SEL_NONE: rd_mux = ALL_ONES;
            endcase
        end
    end

    // Next response state
    always_comb begin
        state_nxt = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_READ, RSP_WACK: begin
                if (req_valid) begin
                    state_nxt = req_write ? RSP_WACK : RSP_READ;
                end
            end
            default: state_nxt = RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else begin
            unique case (state_nxt)
                RSP_READ: rsp_rdata <= rd_mux;
                RSP_WACK: rsp_rdata <= '0;
                RSP_IDLE: rsp_rdata <= '0;
                default:  rsp_rdata <= '0;
            endcase
        end
    end

    assign rsp_valid = (state_q != RSP_IDLE);

    // Stored result is held for visibility of the latched value only.
    logic unused_res;
    assign unused_res = ^res_q;

endmodule

// File: rtl/calc_regblock_chk.sv
module calc_regblock_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              calc_err
);

    logic res_read;
    logic narrow_bad_rd;
    logic id_read;

    assign res_read      = req_valid && !req_write && (req_addr == ADDR_W'('h30)) && (req_size == 4'd4);
    assign narrow_bad_rd = req_valid && !req_write && (req_addr < ADDR_W'('h80)) && (req_size != 4'd4);
    assign id_read       = req_valid && !req_write && (req_addr == '0) && (req_size == 4'd4);

    assert_rsp_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_only_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_read |=> $stable(calc_err));

    assert_err_means_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_read |=> (!calc_err || (rsp_rdata == DATA_W'('hFF))));

    assert_bad_size_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_bad_rd |=> (rsp_rdata == '1));

    assert_id_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        id_read |=> (rsp_rdata == DATA_W'('h0123_4567)));

endmodule

bind calc_regblock calc_regblock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .calc_err  (calc_err)
);

// File: tb/calc_regblock_tb.sv
module calc_regblock_tb;

    localparam int unsigned ADDR_W = 20;
    localparam int unsigned DATA_W = 64;
    localparam logic [63:0] ONES   = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = 4'd4;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              calc_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    calc_regblock u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .calc_err  (calc_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
        end
    endtask

    // One request; response sampled at the following falling edge.
    task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [3:0] sz,
                          input logic [63:0] wd, output logic [63:0] rd, output logic vld);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        rd  = rsp_rdata;
        vld = rsp_valid;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic wr32(input logic [ADDR_W-1:0] a, input logic [63:0] wd);
        logic [63:0] d;
        logic v;
        access(1'b1, a, 4'd4, wd, d, v);
        check("R10 write ack", 64'(v), 64'd1);
    endtask

    task automatic rd_sz(input logic [ADDR_W-1:0] a, input logic [3:0] sz, output logic [63:0] d);
        logic v;
        access(1'b0, a, sz, '0, d, v);
        check("R10 read response", 64'(v), 64'd1);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R10 idle after reset", 64'(rsp_valid), 64'd0);
        check("R1 err reset", 64'(calc_err), 64'd0);
        rd_sz('h10, 4'd4, d); check("R1 opA reset", d, 64'h2);
        rd_sz('h14, 4'd4, d); check("R1 opB reset", d, 64'h4);
        rd_sz('h18, 4'd4, d); check("R1 opcode reset", d, 64'hAA);
        check("R11 err after reg reads", 64'(calc_err), 64'd0);
    endtask

    task automatic t_ident();
        logic [63:0] d;
        rd_sz('h00, 4'd4, d); check("R2 id word", d, 64'h0123_4567);
        wr32('h00, 64'hDEAD_BEEF);
        rd_sz('h00, 4'd4, d); check("R2 id after write", d, 64'h0123_4567);
    endtask

    task automatic t_regs();
        logic [63:0] d;
        wr32('h10, 64'hFFFF_FFFF_CAFE_F00D);
        rd_sz('h10, 4'd4, d); check("R3 opA readback", d, 64'hCAFE_F00D);
        wr32('h14, 64'h1234_5678);
        rd_sz('h14, 4'd4, d); check("R3 opB readback", d, 64'h1234_5678);
        wr32('h18, 64'h7);
        rd_sz('h18, 4'd4, d); check("R3 opcode readback", d, 64'h7);
    endtask

    task automatic t_arith();
        logic [63:0] d;
        wr32('h10, 64'hFFFF_FFFF);
        wr32('h14, 64'h2);
        wr32('h18, 64'h1);
        rd_sz('h30, 4'd4, d); check("R4 add wraps", d, 64'h1);
        check("R7 err clear on add", 64'(calc_err), 64'd0);
        wr32('h10, 64'h3);
        wr32('h14, 64'h5);
        wr32('h18, 64'h2);
        rd_sz('h30, 4'd4, d); check("R5 sub wraps", d, 64'hFFFF_FFFE);
        wr32('h10, 64'h0001_0000);
        wr32('h14, 64'h0001_0001);
        wr32('h18, 64'h3);
        rd_sz('h30, 4'd4, d); check("R6 mul low half", d, 64'h0001_0000);
        wr32('h10, 64'h5);
        rd_sz('h30, 4'd4, d); check("R10 fresh operand in result", d, 64'h0005_0005);
    endtask

    task automatic t_invalid();
        logic [63:0] d;
        wr32('h18, 64'h0);
        rd_sz('h30, 4'd4, d); check("R7 invalid result", d, 64'hFF);
        check("R7 err set", 64'(calc_err), 64'd1);
        wr32('h10, 64'h9);
        rd_sz('h10, 4'd4, d);
        check("R11 err held over reg access", 64'(calc_err), 64'd1);
        wr32('h18, 64'h1);
        check("R11 err held over opcode write", 64'(calc_err), 64'd1);
        rd_sz('h30, 4'd4, d); check("R4 add after invalid", d, 64'h0001_000A);
        check("R7 err cleared", 64'(calc_err), 64'd0);
    endtask

    task automatic t_size();
        logic [63:0] d;
        logic v;
        rd_sz('h10, 4'd2, d); check("R8 narrow read ones", d, ONES);
        rd_sz('h10, 4'd8, d); check("R8 wide read below 0x80 ones", d, ONES);
        access(1'b1, 'h10, 4'd8, 64'h77, d, v);
        access(1'b1, 'h10, 4'd1, 64'h66, d, v);
        rd_sz('h10, 4'd4, d); check("R8 bad-size write ignored", d, 64'h9);
        wr32('h18, 64'h55);
        rd_sz('h30, 4'd8, d); check("R8 bad-size result read ones", d, ONES);
        check("R8 err untouched by bad-size result read", 64'(calc_err), 64'd0);
    endtask

    task automatic t_unmapped();
        logic [63:0] d;
        rd_sz('h04, 4'd4, d); check("R9 unmapped low read", d, ONES);
        rd_sz('h80, 4'd8, d); check("R9 unmapped high 8-byte", d, ONES);
        rd_sz('h84, 4'd4, d); check("R9 unmapped high 4-byte", d, ONES);
        rd_sz('h88, 4'd2, d); check("R9 high bad size", d, ONES);
        wr32('h20, 64'h1111);
        wr32('h30, 64'h2222);
        wr32('h90, 64'h3333);
        rd_sz('h10, 4'd4, d); check("R9 opA untouched", d, 64'h9);
        rd_sz('h14, 4'd4, d); check("R9 opB untouched", d, 64'h0001_0001);
        rd_sz('h18, 4'd4, d); check("R9 opcode untouched", d, 64'h55);
    endtask

    task automatic t_timing();
        @(negedge clk);
        check("R10 no response without request", 64'(rsp_valid), 64'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_regs();
        t_arith();
        t_invalid();
        t_size();
        t_unmapped();
        t_timing();
        finish_run();
    end

endmodule